// File: doc/BRIEF.md
# Byte-Transfer Serial Peripheral Master

This block is a serial peripheral interface master that a processor drives through three byte-wide registers on a simple synchronous bus. A write to the data register, while no transfer is running, loads the transmit shifter and starts an internal serial clock. Eight bits then go out on `mosi` while eight bits are taken in from `miso`. After the eighth bit the serial clock stops, the received byte moves into a receive buffer, a completion flag is raised and, if enabled, an interrupt request is asserted.

The slave-select line is not driven by the engine. It is a bit in the control register that software sets and clears around its transfers. Transmit is single-buffered: a data write during a transfer is refused and a collision flag is set. Receive is double-buffered: the buffer keeps the last byte until the next transfer completes.

The transfer engine is a four-state machine. `ST_IDLE` waits for a start and moves to `ST_HALF_A` on a data write. `ST_HALF_A` is the first half of a bit; `miso` is sampled when its divider tick ends it, and it moves to `ST_HALF_B`. `ST_HALF_B` is the second half; at its tick the shifter moves one place, and it goes back to `ST_HALF_A`, or to `ST_FINISH` after the eighth bit. `ST_FINISH` lasts one cycle, copies the shifter into the receive buffer, raises the completion flag and returns to `ST_IDLE`.

Top module: `spi_byte_master`

## Requirements
- R1: `ss_n` equals control bit 6 (reset value 1) and changes only on a control register write (address 0). It never changes because of a transfer.
- R2: A data register write (address 2) while idle starts a transfer. The busy bit (status bit 0, address 1) reads 1 from the cycle after the write until the transfer ends.
- R3: A transfer makes exactly 8 serial clock periods (16 `sclk` edges). Busy stays 1 for 16·H+1 cycles after the write clock edge, and the completion flag (status bit 7) is 1 when busy drops. Between transfers `sclk` rests at the polarity bit (control bit 2).
- R4: Control bits 5:4 choose the serial clock divisor 4, 16, 64 or 128 (values 0..3). H, the half period in system cycles, is 2, 8, 32 or 64.
- R5: With control bit 1 clear, data moves most significant bit first in both directions. With it set, least significant bit first.
- R6: Control bit 3 is the phase. With phase 0, data is sampled on the leading `sclk` edge and changed on the trailing edge. With phase 1, it is changed on the leading edge and sampled on the trailing edge. All four polarity/phase combinations exchange bytes correctly with a matching slave.
- R7: `irq` is 1 exactly while the completion flag and the interrupt-enable bit (control bit 0) are both 1.
- R8: A data write while busy does not load the shifter and does not change the byte being sent. It sets the collision flag (status bit 6).
- R9: Reading the data register returns the receive buffer. The buffer keeps the last received byte, also during a later transfer, until that transfer completes.
- R10: The completion and collision flags clear only on a data register access (read or write) made after a status read that saw either flag set. A data access with no such status read leaves them set.
- R11: After reset the control register reads 0x40, the status and data registers read 0x00, `ss_n` is 1, and `sclk` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms and clears flags) |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Transfer-complete interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Slave select, software controlled |

## Verification
A data write takes effect on the clock edge that samples it. Busy is visible in the following cycle and stays set for 16·H+1 cycles, and the completion flag, `irq` and the new receive buffer all appear on the same edge that clears busy. The bench drives the bus on falling edges and reads `bus_rdata` just after them. Each status poll therefore counts exactly one cycle, and the busy count is compared with 16·H+1 for every divisor. A behavioural slave in the bench follows `sclk` edges in the chosen mode and records the byte received, and that byte is checked once busy has dropped.

// File: rtl/spi_byte_master_pkg.sv
package spi_byte_master_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned DIV_CNT_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HALF_A,
        ST_HALF_B,
        ST_FINISH
    } xfer_state_t;

    // half serial period in system cycles for each divisor code
    function automatic logic [DIV_CNT_W-1:0] half_cycles(input logic [1:0] sel);
        case (sel)
            2'd0:    half_cycles = DIV_CNT_W'(2);
            2'd1:    half_cycles = DIV_CNT_W'(8);
            2'd2:    half_cycles = DIV_CNT_W'(32);
            default: half_cycles = DIV_CNT_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_byte_master_pkg::*;
#(
    parameter int unsigned CNT_W = DIV_CNT_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(half_cycles(sel)) - CNT_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_byte_master_pkg::*;
#(
    parameter int unsigned WIDTH = BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] tx_byte,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             lsb_first,
    input  logic             tick,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             run,
    output logic             finish,
    output logic [WIDTH-1:0] rx_byte
);
    localparam int unsigned BIT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    xfer_state_t      state_q, state_d;
    logic [WIDTH-1:0] sh_q;
    logic [BIT_W-1:0] bit_q;
    logic             smp_q;
    logic             last_bit;

    assign last_bit = (bit_q == BIT_W'(WIDTH - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_HALF_A;
            ST_HALF_A: if (tick)  state_d = ST_HALF_B;
            ST_HALF_B: if (tick)  state_d = last_bit ? ST_FINISH : ST_HALF_A;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        run    = (state_q == ST_HALF_A) || (state_q == ST_HALF_B);
        finish = (state_q == ST_FINISH);
        sclk   = cpol ^ (cpha ? (state_q == ST_HALF_A) : (state_q == ST_HALF_B));
        mosi   = lsb_first ? sh_q[0] : sh_q[WIDTH-1];
    end

    // shifter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_q   <= '0;
            smp_q   <= 1'b0;
            rx_byte <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    sh_q  <= tx_byte;
                    bit_q <= '0;
                end
                ST_HALF_A: if (tick) smp_q <= miso;
                ST_HALF_B: if (tick) begin
                    sh_q  <= lsb_first ? {smp_q, sh_q[WIDTH-1:1]} : {sh_q[WIDTH-2:0], smp_q};
                    bit_q <= bit_q + BIT_W'(1);
                end
                ST_FINISH: rx_byte <= sh_q;
            endcase
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_master_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       ss_n
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    logic [6:0]        ctrl_q;
    logic              done_flag, wcol_flag, stat_seen;
    logic              xfer_busy, xfer_run, xfer_finish, xfer_start, div_tick;
    logic [BYTE_W-1:0] rx_byte;
    logic              data_wr, data_acc, stat_rd;

    assign data_wr    = bus_wr && (bus_addr == A_DATA);
    assign data_acc   = (bus_wr || bus_rd) && (bus_addr == A_DATA);
    assign stat_rd    = bus_rd && (bus_addr == A_STAT);
    assign xfer_start = data_wr && !xfer_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= 7'h40;
        else if (bus_wr && (bus_addr == A_CTRL))
            ctrl_q <= bus_wdata[6:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            wcol_flag <= 1'b0;
            stat_seen <= 1'b0;
        end else begin
            if (data_acc && stat_seen) begin
                done_flag <= 1'b0;
                wcol_flag <= 1'b0;
                stat_seen <= 1'b0;
            end else if (stat_rd && (done_flag || wcol_flag)) begin
                stat_seen <= 1'b1;
            end
            if (xfer_finish)
                done_flag <= 1'b1;
            if (data_wr && xfer_busy)
                wcol_flag <= 1'b1;
        end
    end

    spi_clk_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (xfer_run),
        .sel   (ctrl_q[5:4]),
        .tick  (div_tick)
    );

    spi_shift_fsm #(.WIDTH(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .tx_byte   (bus_wdata),
        .cpol      (ctrl_q[2]),
        .cpha      (ctrl_q[3]),
        .lsb_first (ctrl_q[1]),
        .tick      (div_tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (xfer_busy),
        .run       (xfer_run),
        .finish    (xfer_finish),
        .rx_byte   (rx_byte)
    );

    assign irq  = done_flag && ctrl_q[0];
    assign ss_n = ctrl_q[6];

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {1'b0, ctrl_q};
            A_STAT:  bus_rdata = {done_flag, wcol_flag, 5'b0, xfer_busy};
            A_DATA:  bus_rdata = rx_byte;
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       ss_n,
    input logic       sclk,
    input logic       cpol,
    input logic       busy,
    input logic       start,
    input logic       done,
    input logic       wcol,
    input logic       rx_load,
    input logic [7:0] rx_byte
);
    // R1
    ss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 2'd0) |=> $stable(ss_n));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    // R3
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R8
    wcol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(busy && bus_wr && bus_addr == 2'd2));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_load |=> $stable(rx_byte));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .cpol     (ctrl_q[2]),
    .busy     (xfer_busy),
    .start    (xfer_start),
    .done     (done_flag),
    .wcol     (wcol_flag),
    .rx_load  (xfer_finish),
    .rx_byte  (rx_byte)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sclk, mosi, ss_n;
    logic       miso = 1'b0;

    int total = 0, bad = 0;
    bit finished = 0;

    // slave model state
    logic       m_cpol = 0, m_cpha = 0, m_lsb = 0;
    logic [7:0] s_tx = 8'h00, m_rx = 8'h00;
    int         cap_i = 0, drv_i = 0, edge_cnt = 0;

    spi_byte_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #2 clk = ~clk;

    function automatic int pos(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    always @(sclk) begin
        if (!ss_n) begin
            logic lead;
            edge_cnt = edge_cnt + 1;
            lead = (sclk != m_cpol);
            if (lead != m_cpha) begin
                if (cap_i < 8) m_rx[pos(cap_i, m_lsb)] = mosi;
                cap_i = cap_i + 1;
            end else begin
                if (drv_i < 8) miso = s_tx[pos(drv_i, m_lsb)];
                drv_i = drv_i + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic configure(input logic [1:0] dv, input logic cpha, input logic cpol,
                             input logic lsb, input logic ien);
        m_cpol = cpol; m_cpha = cpha; m_lsb = lsb;
        bus_write(2'd0, {1'b0, 1'b1, dv, cpha, cpol, lsb, ien});
        bus_write(2'd0, {1'b0, 1'b0, dv, cpha, cpol, lsb, ien});
    endtask

    task automatic slave_prep(input logic [7:0] b);
        s_tx = b; cap_i = 0; edge_cnt = 0; m_rx = 8'h00;
        if (!m_cpha) begin
            miso = b[pos(0, m_lsb)];
            drv_i = 1;
        end else drv_i = 0;
    endtask

    task automatic release_ss(input logic [1:0] dv, input logic cpha, input logic cpol,
                              input logic lsb, input logic ien);
        bus_write(2'd0, {1'b0, 1'b1, dv, cpha, cpol, lsb, ien});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R11 ss_n", ss_n, 1);
        check("R11 sclk", sclk, 0);
        check("R11 irq", irq, 0);
        bus_read(2'd0, v); check("R11 ctrl", v, 8'h40);
        bus_read(2'd1, v); check("R11 stat", v, 8'h00);
        bus_read(2'd2, v); check("R11 data", v, 8'h00);
    endtask

    task automatic t_xfer(input logic [1:0] dv, input logic cpha, input logic cpol,
                          input logic lsb, input logic ien,
                          input logic [7:0] tx, input logic [7:0] stx);
        logic [7:0] v;
        int n, hc;
        hc = (dv == 0) ? 2 : (dv == 1) ? 8 : (dv == 2) ? 32 : 64;
        configure(dv, cpha, cpol, lsb, ien);
        check("R1 ss_n low by software", ss_n, 0);
        check("R3 sclk idle level", sclk, cpol);
        slave_prep(stx);
        bus_read(2'd1, v);
        bus_write(2'd2, tx);
        n = 0;
        v = 8'h01;
        while (v[0] && n < 5000) begin
            bus_read(2'd1, v);
            if (v[0]) n++;
        end
        // R2 R3 R4: busy length 16*H+1 after the write edge
        check("R4 busy cycles", n, 16 * hc + 1);
        check("R3 done flag", v[7], 1);
        check("R3 sclk edges", edge_cnt, 16);
        check("R1 ss_n untouched by transfer", ss_n, 0);
        check("R7 irq", irq, ien);
        check("R5 R6 slave received", m_rx, tx);
        release_ss(dv, cpha, cpol, lsb, ien);
        bus_read(2'd2, v); check("R5 R6 R9 data read", v, stx);
        bus_read(2'd1, v); check("R10 flags cleared", v, 8'h00);
        check("R7 irq cleared", irq, 0);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        configure(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        slave_prep(8'h66);
        bus_write(2'd2, 8'hA5);
        repeat (20) @(negedge clk);
        bus_write(2'd2, 8'h3C);
        bus_read(2'd1, v);
        check("R8 wcol set", v[6], 1);
        check("R2 still busy", v[0], 1);
        v = 8'h01;
        while (v[0]) bus_read(2'd1, v);
        check("R8 byte unchanged", m_rx, 8'hA5);
        check("R8 wcol kept", v[6], 1);
        release_ss(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        bus_read(2'd2, v); check("R8 R9 rx", v, 8'h66);
        bus_read(2'd1, v); check("R10 wcol cleared", v, 8'h00);
    endtask

    task automatic t_flag_hold;
        logic [7:0] v;
        t_xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 8'h5A);
        configure(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        slave_prep(8'hC3);
        bus_write(2'd2, 8'h34);
        repeat (10) @(negedge clk);
        bus_read(2'd2, v); check("R9 buffer held mid-transfer", v, 8'h5A);
        repeat (40) @(negedge clk);
        bus_read(2'd2, v); check("R9 buffer updated", v, 8'hC3);
        bus_read(2'd1, v); check("R10 done kept without status read", v, 8'h80);
        check("R7 irq set", irq, 1);
        bus_read(2'd2, v);
        bus_read(2'd1, v); check("R10 done cleared", v, 8'h00);
        release_ss(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_xfer(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hB4, 8'h2D);
        t_xfer(2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81, 8'h7E);
        t_xfer(2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0F, 8'hE1);
        t_xfer(2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h96, 8'h4B);
        t_collision();
        t_flag_hold();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (150000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule